// File: doc/BRIEF.md
# Per-Core Supply Level Selector

This block places each core of a 16-core cluster on one of three supply rails (low, typical, high) so that every core reaches one shared target clock frequency. Each core's on-die delay monitor reports the highest frequency the core can reach on its present rail, as an unsigned code in MHz. A calibration strobe starts one pass over the cores. The pass begins with core 0 and ends with the last core. A core that reaches the target stays where it is. A core that misses it is moved one rail up, and it is measured again after a programmable settle wait. This repeats until the core meets the target or runs out of rails.

Only one core's rail changes per step. This keeps current steps on the shared supplies small. The rail-select outputs drive external supply switches, one one-hot group per core. A core that was raised earlier can come back down to the low rail in a later pass, but only when the code it last showed on the low rail clears the target by a programmable hysteresis margin. If a core still misses the target on the high rail, its error flag is set.

A typical case uses a target of 830 MHz with all cores first on the low rail (about 0.81 V). Cores that report 820 or 826 MHz there are lifted toward the high rail (about 0.99 V), and the rest stay low.

Top module: `slsel_top`

## Requirements
- R1: After reset every core's rail group reads low (3'b001), all error flags are 0 and busy is 0.
- R2: A calibration strobe sampled while idle starts a pass, and busy is high from the next cycle. The target, hysteresis and settle values are captured at that edge. A strobe or input change during a pass has no effect on that pass and does not queue a new pass. Rails never change while idle.
- R3: A core on the low rail whose code is below the target is moved up one rail. A code equal to or above the target keeps the core on the low rail.
- R4: At most one core's rail changes per cycle. An upward change is always exactly one rail step.
- R5: After a rail change, the same core is evaluated again after settle+1 wait cycles. A pass therefore lasts N evaluation cycles plus settle+2 cycles for every rail change, where N is the number of cores.
- R6: A core that misses the target on the high rail ends the pass on the high rail with its error flag set. The flag clears when that core meets the target in a later pass.
- R7: A core on a raised rail is moved straight to the low rail only when its most recent low-rail code is at least target plus hysteresis. That code is recorded whenever the core is evaluated on the low rail. After the move the core is evaluated again from the low rail.
- R8: Core c owns rail_sel_o bits [3c+2:3c], with bit 0 selecting low, bit 1 typical and bit 2 high. Each group is always one-hot.
- R9: At the end of a pass, every core without an error flag reports a code at or above the target on its selected rail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cal_i | input | 1 | Calibration strobe, starts a pass when idle |
| target_i | input | 11 | Target frequency code in MHz |
| hyst_i | input | 11 | Hysteresis margin for returning to the low rail |
| settle_i | input | 8 | Settle wait length in cycles after a rail change |
| freq_i | input | 176 | Per-core monitor codes, core c at bits [11c+10:11c] |
| rail_sel_o | output | 48 | Per-core one-hot rail select |
| err_o | output | 16 | Per-core error flag, core misses target on the high rail |
| busy_o | output | 1 | A calibration pass is in progress |

## Verification
A strobe driven before a rising edge makes busy visible at the following falling edge, when the bench starts counting. The rails and flags are final once busy has dropped, so they are compared at the first falling edge where busy reads 0. The pass length is measured by counting falling edges with busy high. It is compared with N plus settle+2 for each rail step or return to low that the bench's own model of the pass predicts. The monitor model in the bench derives each core's code from the rail the design currently selects, so re-measurement after every change follows the design's own timing.

// File: rtl/slsel_pkg.sv
package slsel_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EVAL   = 2'd1,
        ST_SETTLE = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_UP   = 2'd1,
        ACT_LOW  = 2'd2
    } rail_act_e;

endpackage

// File: rtl/slsel_seq.sv
module slsel_seq
    import slsel_pkg::*;
#(
    parameter int NUM_CORES = 16,
    parameter int FREQ_W    = 11,
    parameter int SETTLE_W  = 8,
    parameter int NUM_RAILS = 3,
    localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int RAIL_W   = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                cal_i,
    input  logic [FREQ_W-1:0]   target_i,
    input  logic [FREQ_W-1:0]   hyst_i,
    input  logic [SETTLE_W-1:0] settle_i,
    input  logic [FREQ_W-1:0]   cur_freq_i,
    input  logic [RAIL_W-1:0]   cur_rail_i,
    input  logic [FREQ_W-1:0]   cur_low_i,
    output logic [IDX_W-1:0]    idx_o,
    output rail_act_e           act_o,
    output logic                rec_low_o,
    output logic                err_set_o,
    output logic                err_clr_o,
    output logic                busy_o
);

    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_CORES - 1);
    localparam logic [RAIL_W-1:0] TOP_RAIL = RAIL_W'(NUM_RAILS - 1);
    localparam logic [RAIL_W-1:0] LOW_RAIL = '0;

    typedef struct packed {
        seq_state_e          state;
        logic [IDX_W-1:0]    idx;
        logic [SETTLE_W-1:0] cnt;
        logic [FREQ_W-1:0]   target;
        logic [FREQ_W-1:0]   hyst;
        logic [SETTLE_W-1:0] settle;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [FREQ_W:0] lower_thresh;
    logic            miss;
    logic            go_settle;
    logic            advance;

    always_comb begin
        seq_d        = seq_q;
        act_o        = ACT_NONE;
        rec_low_o    = 1'b0;
        err_set_o    = 1'b0;
        err_clr_o    = 1'b0;
        go_settle    = 1'b0;
        advance      = 1'b0;
        lower_thresh = {1'b0, seq_q.target} + {1'b0, seq_q.hyst};
        miss         = cur_freq_i < seq_q.target;

        unique case (seq_q.state)
            ST_IDLE: begin
                if (cal_i) begin
                    seq_d.state  = ST_EVAL;
                    seq_d.idx    = '0;
                    seq_d.cnt    = '0;
                    seq_d.target = target_i;
                    seq_d.hyst   = hyst_i;
                    seq_d.settle = settle_i;
                end
            end
            ST_EVAL: begin
                if (cur_rail_i == LOW_RAIL) begin
                    rec_low_o = 1'b1;
                    if (miss) begin
                        act_o     = ACT_UP;
                        go_settle = 1'b1;
                    end else begin
                        err_clr_o = 1'b1;
                        advance   = 1'b1;
                    end
                end else if ({1'b0, cur_low_i} >= lower_thresh) begin
                    act_o     = ACT_LOW;
                    go_settle = 1'b1;
                end else if (!miss) begin
                    err_clr_o = 1'b1;
                    advance   = 1'b1;
                end else if (cur_rail_i != TOP_RAIL) begin
                    act_o     = ACT_UP;
                    go_settle = 1'b1;
                end else begin
                    err_set_o = 1'b1;
                    advance   = 1'b1;
                end

                if (go_settle) begin
                    seq_d.state = ST_SETTLE;
                    seq_d.cnt   = '0;
                end else if (advance) begin
                    if (seq_q.idx == LAST_IDX) begin
                        seq_d.state = ST_IDLE;
                        seq_d.idx   = '0;
                    end else begin
                        seq_d.idx = seq_q.idx + 1'b1;
                    end
                end
            end
            ST_SETTLE: begin
                if (seq_q.cnt >= seq_q.settle) begin
                    seq_d.state = ST_EVAL;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seq_q.state  <= ST_IDLE;
            seq_q.idx    <= '0;
            seq_q.cnt    <= '0;
            seq_q.target <= '0;
            seq_q.hyst   <= '0;
            seq_q.settle <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign idx_o  = seq_q.idx;
    assign busy_o = (seq_q.state != ST_IDLE);

    AST_CAL_STARTS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.state == ST_IDLE && cal_i) |=> (seq_q.state == ST_EVAL && seq_q.idx == '0)); // R2

    AST_IDLE_NO_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.state != ST_EVAL) |-> (act_o == ACT_NONE)); // R2

    AST_CHANGE_THEN_SETTLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_o != ACT_NONE) |=> (seq_q.state == ST_SETTLE && seq_q.cnt == '0)); // R5

    AST_PARAMS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o)) |-> ($stable(seq_q.target) && $stable(seq_q.hyst))); // R2

endmodule

// File: rtl/slsel_slot.sv
module slsel_slot
    import slsel_pkg::*;
#(
    parameter int FREQ_W    = 11,
    parameter int NUM_RAILS = 3,
    localparam int RAIL_W   = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 sel_i,
    input  rail_act_e            act_i,
    input  logic                 rec_low_i,
    input  logic                 err_set_i,
    input  logic                 err_clr_i,
    input  logic [FREQ_W-1:0]    freq_i,
    output logic [RAIL_W-1:0]    rail_o,
    output logic [NUM_RAILS-1:0] rail_sel_o,
    output logic [FREQ_W-1:0]    low_code_o,
    output logic                 err_o
);

    localparam logic [RAIL_W-1:0] TOP_RAIL = RAIL_W'(NUM_RAILS - 1);

    typedef struct packed {
        logic [RAIL_W-1:0] rail;
        logic [FREQ_W-1:0] low_code;
        logic              err;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (sel_i) begin
            if (rec_low_i) begin
                slot_d.low_code = freq_i;
            end
            unique case (act_i)
                ACT_UP:   if (slot_q.rail != TOP_RAIL) slot_d.rail = slot_q.rail + 1'b1;
                ACT_LOW:  slot_d.rail = '0;
                default:  slot_d.rail = slot_q.rail;
            endcase
            if (err_set_i) begin
                slot_d.err = 1'b1;
            end else if (err_clr_i || act_i == ACT_LOW) begin
                slot_d.err = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            slot_q.rail     <= '0;
            slot_q.low_code <= '0;
            slot_q.err      <= 1'b0;
        end else begin
            slot_q <= slot_d;
        end
    end

    for (genvar r = 0; r < NUM_RAILS; r++) begin : g_dec
        assign rail_sel_o[r] = (slot_q.rail == RAIL_W'(r));
    end

    assign rail_o     = slot_q.rail;
    assign low_code_o = slot_q.low_code;
    assign err_o      = slot_q.err;

    AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot(rail_sel_o)); // R8

    AST_SINGLE_STEP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slot_q.rail > $past(slot_q.rail)) |-> (slot_q.rail == $past(slot_q.rail) + 1'b1)); // R4

    AST_ERR_ONLY_AT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> (rail_sel_o[NUM_RAILS-1] == 1'b1)); // R6

    AST_UNSELECTED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sel_i |=> $stable(slot_q)); // R4

endmodule

// File: rtl/slsel_top.sv
module slsel_top
    import slsel_pkg::*;
#(
    parameter int NUM_CORES = 16,
    parameter int FREQ_W    = 11,
    parameter int SETTLE_W  = 8,
    parameter int NUM_RAILS = 3,
    localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int RAIL_W   = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           cal_i,
    input  logic [FREQ_W-1:0]              target_i,
    input  logic [FREQ_W-1:0]              hyst_i,
    input  logic [SETTLE_W-1:0]            settle_i,
    input  logic [NUM_CORES*FREQ_W-1:0]    freq_i,
    output logic [NUM_CORES*NUM_RAILS-1:0] rail_sel_o,
    output logic [NUM_CORES-1:0]           err_o,
    output logic                           busy_o
);

    logic [IDX_W-1:0]  idx;
    rail_act_e         act;
    logic              rec_low;
    logic              err_set;
    logic              err_clr;

    logic [FREQ_W-1:0] freq_arr [NUM_CORES];
    logic [RAIL_W-1:0] rail_arr [NUM_CORES];
    logic [FREQ_W-1:0] low_arr  [NUM_CORES];

    logic [FREQ_W-1:0] cur_freq;
    logic [RAIL_W-1:0] cur_rail;
    logic [FREQ_W-1:0] cur_low;

    assign cur_freq = freq_arr[idx];
    assign cur_rail = rail_arr[idx];
    assign cur_low  = low_arr[idx];

    slsel_seq #(
        .NUM_CORES (NUM_CORES),
        .FREQ_W    (FREQ_W),
        .SETTLE_W  (SETTLE_W),
        .NUM_RAILS (NUM_RAILS)
    ) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cal_i      (cal_i),
        .target_i   (target_i),
        .hyst_i     (hyst_i),
        .settle_i   (settle_i),
        .cur_freq_i (cur_freq),
        .cur_rail_i (cur_rail),
        .cur_low_i  (cur_low),
        .idx_o      (idx),
        .act_o      (act),
        .rec_low_o  (rec_low),
        .err_set_o  (err_set),
        .err_clr_o  (err_clr),
        .busy_o     (busy_o)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        assign freq_arr[c] = freq_i[c*FREQ_W +: FREQ_W];

        slsel_slot #(
            .FREQ_W    (FREQ_W),
            .NUM_RAILS (NUM_RAILS)
        ) u_slot (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .sel_i      (busy_o && (idx == IDX_W'(c))),
            .act_i      (act),
            .rec_low_i  (rec_low),
            .err_set_i  (err_set),
            .err_clr_i  (err_clr),
            .freq_i     (freq_arr[c]),
            .rail_o     (rail_arr[c]),
            .rail_sel_o (rail_sel_o[c*NUM_RAILS +: NUM_RAILS]),
            .low_code_o (low_arr[c]),
            .err_o      (err_o[c])
        );
    end

    AST_ONE_CORE_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($countones(rail_sel_o ^ $past(rail_sel_o)) <= 2)); // R4

    AST_IDLE_RAILS_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |=> $stable(rail_sel_o)); // R2

endmodule

// File: tb/slsel_top_bench.sv
module slsel_top_bench;

    localparam int NC    = 16;
    localparam int FW    = 11;
    localparam int SW    = 8;
    localparam int NR    = 3;
    localparam int STEP  = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cal = 1'b0;
    logic [FW-1:0]   target = '0;
    logic [FW-1:0]   hyst = '0;
    logic [SW-1:0]   settle = '0;
    logic [NC*FW-1:0] freq_bus;
    logic [NC*NR-1:0] rail_sel;
    logic [NC-1:0]   err;
    logic            busy;

    int unsigned base [NC];
    int unsigned m_rail [NC];
    int unsigned m_low  [NC];
    bit          m_err  [NC];

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    slsel_top u_slsel_top (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .cal_i      (cal),
        .target_i   (target),
        .hyst_i     (hyst),
        .settle_i   (settle),
        .freq_i     (freq_bus),
        .rail_sel_o (rail_sel),
        .err_o      (err),
        .busy_o     (busy)
    );

    function automatic int unsigned rail_of(int c);
        if (rail_sel[c*NR+2]) return 2;
        if (rail_sel[c*NR+1]) return 1;
        return 0;
    endfunction

    // monitor model: code rises by STEP per rail above low
    always_comb begin
        for (int c = 0; c < NC; c++) begin
            freq_bus[c*FW +: FW] = FW'(base[c] + rail_of(c) * STEP);
        end
    end

    task automatic check(input string req, input int unsigned act, input int unsigned exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // bench model of one pass; returns busy cycle count
    function automatic int unsigned model_pass(int unsigned t, int unsigned h, int unsigned s);
        int unsigned cyc = 0;
        for (int c = 0; c < NC; c++) begin
            bit done = 0;
            while (!done) begin
                int unsigned f = base[c] + m_rail[c] * STEP;
                if (m_rail[c] == 0) begin
                    m_low[c] = f;
                    if (f < t) begin m_rail[c] = 1; cyc += s + 2; end
                    else begin m_err[c] = 0; cyc += 1; done = 1; end
                end else if (m_low[c] >= t + h) begin
                    m_rail[c] = 0; m_err[c] = 0; cyc += s + 2;
                end else if (f >= t) begin
                    m_err[c] = 0; cyc += 1; done = 1;
                end else if (m_rail[c] < NR - 1) begin
                    m_rail[c] += 1; cyc += s + 2;
                end else begin
                    m_err[c] = 1; cyc += 1; done = 1;
                end
            end
        end
        return cyc;
    endfunction

    task automatic run_pass(input int unsigned t, input int unsigned h, input int unsigned s, input bit poke);
        int unsigned exp_cyc;
        int unsigned got = 0;
        @(negedge clk);
        target = FW'(t); hyst = FW'(h); settle = SW'(s); cal = 1'b1;
        @(negedge clk);
        cal = 1'b0;
        check("R2", busy, 1, "busy after strobe");
        while (busy && got < 5000) begin
            got++;
            if (poke && got == 3) begin
                cal = 1'b1; target = '0; hyst = '0; settle = SW'(200);
            end else begin
                cal = 1'b0;
            end
            @(negedge clk);
        end
        cal = 1'b0;
        exp_cyc = model_pass(t, h, s);
        check("R5", got, exp_cyc, "pass length");
        for (int c = 0; c < NC; c++) begin
            check("R3", rail_of(c), m_rail[c], $sformatf("rail core %0d", c));
            check("R6", err[c], m_err[c], $sformatf("err core %0d", c));
            check("R8", rail_sel[c*NR +: NR], 3'b001 << m_rail[c], $sformatf("onehot core %0d", c));
            if (!err[c]) check("R9", (base[c] + rail_of(c) * STEP >= t), 1, $sformatf("meets target core %0d", c));
        end
        repeat (3) @(negedge clk);
        check("R2", busy, 0, "no queued pass");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        base = '{862, 909, 870, 847, 826, 855, 877, 893, 820, 826, 909, 847, 901, 917, 847, 901};
        for (int c = 0; c < NC; c++) begin m_rail[c] = 0; m_low[c] = 0; m_err[c] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", busy, 0, "busy after reset");
        check("R1", err, 0, "err after reset");
        for (int c = 0; c < NC; c++) check("R1", rail_sel[c*NR +: NR], 3'b001, $sformatf("reset rail core %0d", c));
        // R3: typical case, 820/826 cores raised
        run_pass(830, 20, 3, 1'b0);
        check("R3", rail_of(4), 1, "826 core on typical");
        check("R3", rail_of(8), 2, "820 core on high");
        check("R3", rail_of(0), 0, "862 core stays low");
        // R6 errors at high target; R2 strobe during pass ignored
        run_pass(900, 0, 0, 1'b1);
        check("R6", err[3], 1, "847 core misses at high");
        // R7 hysteresis: only low codes >= 870 return low
        run_pass(830, 40, 2, 1'b0);
        check("R7", rail_of(6), 0, "877 core back to low");
        check("R7", rail_of(3), 2, "847 core stays high");
        check("R6", err[3], 0, "err cleared on meeting target");
        // shifted bases
        for (int c = 0; c < NC; c++) base[c] = base[c] + 10;
        run_pass(820, 10, 1, 1'b0);
        // sweep of targets, hysteresis and settle lengths
        for (int t = 800; t <= 960; t += 20) begin
            run_pass(t, ((t / 20) % 3) * 8, t % 4, (t % 40) == 0);
        end
        for (int c = 0; c < NC; c++) base[c] = 800 + c * 9;
        for (int t = 950; t >= 790; t -= 40) begin
            run_pass(t, (t % 3) * 5, 5, 1'b0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule